// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block decides whether exclusive stores succeed, for a set of requesters that use load-exclusive / store-exclusive pairs to build atomic read-modify-write sequences. It watches one request stream. Each request carries an operation (plain load, plain store, exclusive load, exclusive store), an address, a shareable flag and a requester number. For every exclusive store it returns one status bit one cycle later. A zero means the store may write memory. A one means the store must be dropped and the software loop must try again.

Each requester owns a private reservation tracker, and every exclusive access consults it. Each requester also holds an entry in a system-wide tracker, which is consulted only for shareable addresses. Every tracker has two states, open and reserved, and keeps the reserved address. A plain store, or a successful exclusive store, by a different requester to a reserved shareable address knocks out that reservation. Memory itself, arbitration and coherence are outside the block.

Top module: `excl_monitor`

## Requirements
- R1: After reset every tracker is open, so an exclusive store fails until an exclusive load has been made; `rsp_valid` is 0 while in reset.
- R2: Operation codes are 0 plain load, 1 plain store, 2 exclusive load, 3 exclusive store. Exactly one cycle after an accepted exclusive store, `rsp_valid` is 1 and `rsp_id` equals its requester. No other operation produces a response.
- R3: An exclusive store to the address reserved by the same requester's latest exclusive load returns `rsp_fail`=0 (the store may proceed).
- R4: An exclusive store while the requester's private tracker is open returns `rsp_fail`=1 and leaves the tracker open.
- R5: An exclusive store whose address differs from the reserved address fails and clears the reservation.
- R6: A successful exclusive store returns the tracker to open, so an immediate repeat fails.
- R7: A non-shareable exclusive store consults only the private tracker. Plain stores and loads by others, and the state of the system-wide tracker, do not affect it.
- R8: A shareable exclusive store also requires a reserved, address-matching system-wide entry for its requester. A shareable plain store by another requester to that address clears the entry. A store to a different address does not.
- R9: A successful shareable exclusive store by one requester clears other requesters' system-wide reservations on the same address. A failed one, which writes nothing, clears none.
- R10: Reservations of different requesters are independent; one requester's exclusive load or store does not disturb another's private tracker.
- R11: A plain load changes no tracker, and a new exclusive load replaces the reserved address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | ADDR_W | Access address |
| req_shared | input | 1 | Address is shareable |
| req_id | input | ID_W | Requester number |
| rsp_valid | output | 1 | Status for last cycle's exclusive store |
| rsp_fail | output | 1 | 1 = store refused, 0 = store may write |
| rsp_id | output | ID_W | Requester the status belongs to |

## Verification
The case hardest to reach from the ports is a shareable reservation that is still held privately but has been lost in the system-wide tracker, because another requester's store wrote the address. The stimulus builds it by having a second requester interleave plain and exclusive stores between the first requester's exclusive load and store. It then checks both the passing and the failing variant of the intervening store. The stimulus also issues a non-shareable exclusive store over a lost shareable reservation. This shows that the two levels really are consulted separately.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    OP_LD  = 2'd0,
    OP_ST  = 2'd1,
    OP_LDX = 2'd2,
    OP_STX = 2'd3
  } excl_op_e;

  // Exclusive store verdict: private reservation always required,
  // system-wide one only for shareable addresses. Returns 1 on pass.
  function automatic logic stx_verdict(input logic loc_ok,
                                       input logic glb_ok,
                                       input logic shared);
    return loc_ok && (!shared || glb_ok);
  endfunction

  // Whether an access writes memory and so may break remote reservations.
  function automatic logic writes_memory(input logic [1:0] op,
                                         input logic stx_pass);
    return (op == OP_ST) || ((op == OP_STX) && stx_pass);
  endfunction

endpackage

// File: rtl/excl_local_mon.sv
module excl_local_mon
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 1,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              excl_o,
  output logic              match_o
);

  logic              excl_q;
  logic [ADDR_W-1:0] tag_q;
  logic              mine;
  logic              ldx_self;
  logic              stx_self;

  function automatic logic tag_hit(input logic ex, input logic [ADDR_W-1:0] t,
                                   input logic [ADDR_W-1:0] a);
    return ex && (t == a);
  endfunction

  assign mine     = req_valid && (req_id == ID_W'(MY_ID));
  assign ldx_self = mine && (req_op == OP_LDX);
  assign stx_self = mine && (req_op == OP_STX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl_q <= 1'b0;
      tag_q  <= '0;
    end else if (ldx_self) begin
      excl_q <= 1'b1;
      tag_q  <= req_addr;
    end else if (stx_self) begin
      excl_q <= 1'b0;
    end
  end

  assign excl_o  = excl_q;
  assign match_o = tag_hit(excl_q, tag_q, req_addr);

  p_ldx_reserves_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ldx_self |=> (excl_q && tag_q == $past(req_addr)));

  p_stx_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stx_self |=> !excl_q);

  p_others_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mine || req_op == OP_LD || req_op == OP_ST) |=> $stable(excl_q));

endmodule

// File: rtl/excl_global_mon.sv
module excl_global_mon
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 1,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_shared,
  input  logic [ID_W-1:0]   req_id,
  input  logic              wr_commit,
  output logic              match_o
);

  logic              excl_q;
  logic [ADDR_W-1:0] tag_q;
  logic              own_sh;
  logic              remote_hit;

  assign own_sh     = req_valid && req_shared && (req_id == ID_W'(MY_ID));
  assign remote_hit = wr_commit && (req_id != ID_W'(MY_ID)) &&
                      excl_q && (tag_q == req_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl_q <= 1'b0;
      tag_q  <= '0;
    end else if (own_sh && req_op == OP_LDX) begin
      excl_q <= 1'b1;
      tag_q  <= req_addr;
    end else if (own_sh && req_op == OP_STX) begin
      excl_q <= 1'b0;
    end else if (remote_hit) begin
      excl_q <= 1'b0;
    end
  end

  assign match_o = excl_q && (tag_q == req_addr);

  p_remote_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    remote_hit |=> !excl_q);

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_REQ = 2,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_shared,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic              rsp_fail,
  output logic [ID_W-1:0]   rsp_id
);

  logic [NUM_REQ-1:0] loc_excl;
  logic [NUM_REQ-1:0] loc_match;
  logic [NUM_REQ-1:0] glb_match;
  logic               stx_req;
  logic               stx_pass;
  logic               wr_commit;
  logic               loc_excl_sel;
  logic               glb_match_sel;

  assign stx_req       = req_valid && (req_op == OP_STX);
  assign loc_excl_sel  = loc_excl[req_id];
  assign glb_match_sel = glb_match[req_id];
  assign stx_pass      = stx_verdict(loc_match[req_id], glb_match_sel, req_shared);
  assign wr_commit     = req_valid && req_shared && writes_memory(req_op, stx_pass);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    excl_local_mon #(.ADDR_W(ADDR_W), .ID_W(ID_W), .MY_ID(g)) u_loc (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_op   (req_op),
      .req_addr (req_addr),
      .req_id   (req_id),
      .excl_o   (loc_excl[g]),
      .match_o  (loc_match[g])
    );
    excl_global_mon #(.ADDR_W(ADDR_W), .ID_W(ID_W), .MY_ID(g)) u_glb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .req_shared(req_shared),
      .req_id    (req_id),
      .wr_commit (wr_commit),
      .match_o   (glb_match[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_id    <= '0;
    end else begin
      rsp_valid <= stx_req;
      if (stx_req) begin
        rsp_fail <= !stx_pass;
        rsp_id   <= req_id;
      end
    end
  end

  p_rsp_follows_stx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stx_req |=> (rsp_valid && rsp_id == $past(req_id)));

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stx_req |=> !rsp_valid);

  p_open_fails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_req && !loc_excl_sel) |=> rsp_fail);

  p_shared_needs_glb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_req && req_shared && !glb_match_sel) |=> rsp_fail);

endmodule

// File: tb/excl_monitor_bench.sv
`timescale 1ns/1ps
module excl_monitor_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic          req_shared = 1'b0;
  logic [0:0]    req_id = 1'b0;
  logic          rsp_valid;
  logic          rsp_fail;
  logic [0:0]    rsp_id;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .NUM_REQ(2)) u_excl_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_shared(req_shared), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_id(rsp_id)
  );

  // Behavioural reference: reservation tables indexed by requester.
  bit          m_lx[2];
  bit [AW-1:0] m_lt[2];
  bit          m_gx[2];
  bit [AW-1:0] m_gt[2];
  bit          e_valid, e_fail;
  bit          e_id;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_lx[k]) begin m_lx[k] = 0; m_gx[k] = 0; end
      e_valid = 0;
    end else begin
      int  who;
      bit  ok;
      bit  wrote;
      who = int'(req_id);
      e_valid = req_valid && req_op == 2'd3;
      ok = m_lx[who] && m_lt[who] == req_addr &&
           (!req_shared || (m_gx[who] && m_gt[who] == req_addr));
      if (e_valid) begin e_fail = !ok; e_id = req_id; end
      if (req_valid) begin
        wrote = (req_op == 2'd1) || (req_op == 2'd3 && ok);
        if (req_shared && wrote)
          for (int j = 0; j < 2; j++)
            if (j != who && m_gx[j] && m_gt[j] == req_addr) m_gx[j] = 0;
        if (req_op == 2'd2) begin
          m_lx[who] = 1; m_lt[who] = req_addr;
          if (req_shared) begin m_gx[who] = 1; m_gt[who] = req_addr; end
        end else if (req_op == 2'd3) begin
          m_lx[who] = 0;
          if (req_shared) m_gx[who] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rsp_valid !== e_valid ||
          (e_valid && (rsp_fail !== e_fail || rsp_id !== e_id))) begin
        errors++;
        $display("FAIL R2 model: valid/fail/id got %0b/%0b/%0d expected %0b/%0b/%0d",
                 rsp_valid, rsp_fail, rsp_id, e_valid, e_fail, e_id);
      end
    end
  end

  localparam logic [AW-1:0] A = 32'h0000_0100;
  localparam logic [AW-1:0] B = 32'h0000_0200;

  // exp: -1 no directed check, 0 pass expected, 1 fail expected
  task automatic op(input logic [1:0] o, input logic [AW-1:0] a, input logic sh,
                    input logic id, input int exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_op = o; req_addr = a; req_shared = sh; req_id = id;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (exp >= 0) begin
      checks++;
      if (!(rsp_valid === 1'b1 && rsp_fail === exp[0] && rsp_id === id)) begin
        errors++;
        $display("FAIL %s: valid/fail/id got %0b/%0b/%0d expected 1/%0d/%0d",
                 tag, rsp_valid, rsp_fail, rsp_id, exp, id);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req_valid = 0;
    @(negedge clk); @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rsp_valid in reset got %0b expected 0", rsp_valid);
    end
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    op(2'd3, A, 0, 0, 1, "R1 stx after reset");
    op(2'd3, A, 0, 0, 1, "R4 open stays open");
    op(2'd2, A, 0, 0, -1, "");
    op(2'd3, A, 0, 0, 0, "R3 matched stx");
    op(2'd3, A, 0, 0, 1, "R6 repeat after success");
    op(2'd2, A, 0, 0, -1, "");
    op(2'd3, B, 0, 0, 1, "R5 mismatch");
    op(2'd3, A, 0, 0, 1, "R5 reservation cleared");
    op(2'd2, A, 0, 0, -1, "");
    op(2'd1, A, 0, 1, -1, "");
    op(2'd0, A, 0, 0, -1, "");
    op(2'd3, A, 0, 0, 0, "R7 R11 nonshared unaffected");
    op(2'd2, A, 1, 0, -1, "");
    op(2'd1, A, 1, 1, -1, "");
    op(2'd3, A, 1, 0, 1, "R8 remote store clears");
    op(2'd2, A, 1, 0, -1, "");
    op(2'd1, B, 1, 1, -1, "");
    op(2'd3, A, 1, 0, 0, "R8 other address kept");
    op(2'd2, A, 1, 0, -1, "");
    op(2'd2, A, 1, 1, -1, "");
    op(2'd3, A, 1, 1, 0, "R9 first winner");
    op(2'd3, A, 1, 0, 1, "R9 loser");
    op(2'd2, A, 1, 0, -1, "");
    op(2'd3, A, 1, 1, 1, "R9 failed remote stx");
    op(2'd3, A, 1, 0, 0, "R9 failed stx clears nothing");
    op(2'd2, A, 0, 0, -1, "");
    op(2'd2, B, 0, 1, -1, "");
    op(2'd3, B, 0, 1, 0, "R10 requester1");
    op(2'd3, A, 0, 0, 0, "R10 requester0 intact");
    op(2'd2, A, 0, 0, -1, "");
    op(2'd2, B, 0, 0, -1, "");
    op(2'd3, A, 0, 0, 1, "R11 retag replaces");
    op(2'd2, A, 0, 0, -1, "");
    op(2'd3, A, 1, 0, 1, "R8 shared without global");
    op(2'd2, A, 1, 0, -1, "");
    op(2'd1, A, 1, 1, -1, "");
    op(2'd3, A, 0, 0, 0, "R7 nonshared ignores global");
    op(2'd2, A, 0, 0, -1, "");
    do_reset();
    op(2'd3, A, 0, 0, 1, "R1 reset clears reservation");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule